// File: doc/BRIEF.md
# Framed Acquisition Gate Controller

This block drives one acquisition-enable gate that both converter channels share, so the two channels always start and stop on the same sample. It runs in one of two modes. In continuous mode the gate follows the level of the selected trigger, one cycle late. In framed mode each rising edge of the trigger opens the gate for a programmed number of valid samples. The gate then closes by itself, a one-cycle completion pulse is issued, and the controller re-arms.

The trigger comes either from a software-written level bit or from an external asynchronous pin, which the block synchronizes first. The frame length is checked all the time. Legal lengths are multiples of eight from 8 to 16,777,216. An illegal length raises an error flag and blocks any frame start. The length is captured when a frame starts, so rewriting it during a frame only affects the next frame.

Top module: `acq_gate_ctrl`

## Requirements
- R1: After reset `acq_gate`, `frame_done` and `size_err` are all low.
- R2: With `trig_src_ext` low, the trigger is `sw_trig` and `ext_trig` has no effect. With it high, the trigger is the synchronized `ext_trig` and `sw_trig` has no effect.
- R3: `ext_trig` passes through a two-flop synchronizer. In framed mode, a rising edge of `ext_trig` captured at clock edge k opens `acq_gate` after edge k+2.
- R4: With `mode_framed` low, `acq_gate` at every edge takes the level the selected trigger had just before that edge.
- R5: With `mode_framed` high, a low-to-high change of the selected trigger seen at an edge, with a legal length, raises `acq_gate` after that edge. The gate stays high until exactly N samples with `sample_valid` high have been taken at edges while the gate was high. N is `frame_len`, read as an unsigned number.
- R6: `frame_done` is high for exactly one cycle. It rises at the same edge at which `acq_gate` falls after the Nth sample, and the controller is then idle and ready for a new start.
- R7: A trigger rising edge while a frame is open neither restarts nor extends the frame.
- R8: A length is legal when it is a multiple of 8 and lies between 8 and 16,777,216. `size_err` shows, one cycle after `frame_len` changes, whether the new value is illegal. A start with an illegal length leaves `acq_gate` low.
- R9: `frame_len` is captured at the start edge. A change during a frame does not alter that frame's length.
- R10: Dropping `mode_framed` during a frame abandons the frame without a `frame_done` pulse. Raising it again does not resume the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_framed | input | 1 | 1 = framed mode, 0 = continuous mode |
| trig_src_ext | input | 1 | 1 = external trigger selected, 0 = software bit |
| sw_trig | input | 1 | Software trigger level |
| ext_trig | input | 1 | Asynchronous external trigger |
| frame_len | input | 25 | Frame length in samples |
| sample_valid | input | 1 | A converter sample is present this cycle |
| acq_gate | output | 1 | Acquisition enable for both channels |
| frame_done | output | 1 | One-cycle pulse at the end of a frame |
| size_err | output | 1 | Current `frame_len` is illegal |

## Verification
A wrong remaining-sample count shows up as a gate that is open for the wrong number of valid samples. This becomes visible at the very cycle `frame_done` fires, or fails to fire. A controller stuck in the running state shows up as a gate that never closes. A controller that wrongly leaves the running state shows up as an early gate fall without a done pulse, within one cycle. Retrigger and capture faults only show up at the end of the affected frame, so the scoreboard compares the number of gated valid samples against the length of every frame.

// File: rtl/acq_gate_pkg.sv
package acq_gate_pkg;

  typedef enum logic {
    FS_IDLE = 1'b0,
    FS_RUN  = 1'b1
  } frame_state_e;

  // Frame length rule: aligned to step, and inside [lo, hi].
  function automatic logic len_is_legal(input logic [31:0] len,
                                        input logic [31:0] lo,
                                        input logic [31:0] hi,
                                        input logic [31:0] step);
    return (len >= lo) && (len <= hi) && ((len % step) == 32'd0);
  endfunction

  // Initial value of the down-counter for a frame of len samples.
  function automatic logic [31:0] first_remaining(input logic [31:0] len);
    return len - 32'd1;
  endfunction

endpackage

// File: rtl/trig_front.sv
module trig_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_ext,
  input  logic sw_trig,
  input  logic ext_trig,
  output logic trig_level,
  output logic trig_rise
);
  logic ext_sync;
  logic level_prev;

  generate
    if (SYNC_STAGES <= 1) begin : g_one
      logic s_q;
      always_ff @(posedge clk) begin
        if (!rst_n) s_q <= 1'b0;
        else        s_q <= ext_trig;
      end
      assign ext_sync = s_q;
    end else begin : g_chain
      logic [SYNC_STAGES-1:0] s_q;
      always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= {s_q[SYNC_STAGES-2:0], ext_trig};
      end
      assign ext_sync = s_q[SYNC_STAGES-1];
    end
  endgenerate

  assign trig_level = src_ext ? ext_sync : sw_trig;

  always_ff @(posedge clk) begin
    if (!rst_n) level_prev <= 1'b0;
    else        level_prev <= trig_level;
  end

  assign trig_rise = trig_level & ~level_prev;
endmodule

// File: rtl/frame_engine.sv
module frame_engine
  import acq_gate_pkg::*;
#(
  parameter int LEN_W = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             framed,
  input  logic             start,
  input  logic             len_good,
  input  logic [LEN_W-1:0] len_in,
  input  logic             sample_valid,
  input  logic             cont_level,
  output logic             gate,
  output logic             done,
  output logic             run,
  output logic             last_sample,
  output logic [LEN_W-1:0] remaining
);
  frame_state_e     st_q, st_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic             done_q, done_d;
  logic             gate_q, gate_d;

  assign last_sample = (st_q == FS_RUN) && sample_valid && (rem_q == '0);

  always_comb begin
    st_d   = st_q;
    rem_d  = rem_q;
    done_d = 1'b0;
    if (!framed) begin
      st_d = FS_IDLE;
    end else begin
      unique case (st_q)
        FS_IDLE: if (start && len_good) begin
          st_d  = FS_RUN;
          rem_d = LEN_W'(first_remaining(32'(len_in)));
        end
        FS_RUN: if (sample_valid) begin
          if (rem_q == '0) begin
            st_d   = FS_IDLE;
            done_d = 1'b1;
          end else begin
            rem_d = rem_q - 1'b1;
          end
        end
        default: st_d = FS_IDLE;
      endcase
    end
    gate_d = framed ? (st_d == FS_RUN) : cont_level;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= FS_IDLE;
      rem_q  <= '0;
      done_q <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      rem_q  <= rem_d;
      done_q <= done_d;
      gate_q <= gate_d;
    end
  end

  assign gate      = gate_q;
  assign done      = done_q;
  assign run       = (st_q == FS_RUN);
  assign remaining = rem_q;
endmodule

// File: rtl/acq_gate_ctrl.sv
module acq_gate_ctrl
  import acq_gate_pkg::*;
#(
  parameter int LEN_W       = 25,
  parameter int MIN_LEN     = 8,
  parameter int MAX_LEN     = 1 << 24,
  parameter int LEN_STEP    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_framed,
  input  logic             trig_src_ext,
  input  logic             sw_trig,
  input  logic             ext_trig,
  input  logic [LEN_W-1:0] frame_len,
  input  logic             sample_valid,
  output logic             acq_gate,
  output logic             frame_done,
  output logic             size_err
);
  // Named internal events, observed by the bound checker.
  logic             trig_level;
  logic             start_evt;
  logic             len_good;
  logic             run_st;
  logic             last_sample;
  logic [LEN_W-1:0] rem;
  logic             size_err_q;

  assign len_good = len_is_legal(32'(frame_len), 32'(MIN_LEN),
                                 32'(MAX_LEN), 32'(LEN_STEP));

  trig_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_ext    (trig_src_ext),
    .sw_trig    (sw_trig),
    .ext_trig   (ext_trig),
    .trig_level (trig_level),
    .trig_rise  (start_evt)
  );

  frame_engine #(.LEN_W(LEN_W)) u_engine (
    .clk          (clk),
    .rst_n        (rst_n),
    .framed       (mode_framed),
    .start        (start_evt),
    .len_good     (len_good),
    .len_in       (frame_len),
    .sample_valid (sample_valid),
    .cont_level   (trig_level),
    .gate         (acq_gate),
    .done         (frame_done),
    .run          (run_st),
    .last_sample  (last_sample),
    .remaining    (rem)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) size_err_q <= 1'b0;
    else        size_err_q <= ~len_good;
  end

  assign size_err = size_err_q;
endmodule

// File: rtl/acq_gate_chk.sv
module acq_gate_chk #(
  parameter int LEN_W   = 25,
  parameter int MAX_LEN = 1 << 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_framed,
  input logic             acq_gate,
  input logic             frame_done,
  input logic             trig_level,
  input logic             start_evt,
  input logic             len_good,
  input logic             run_st,
  input logic             last_sample,
  input logic [LEN_W-1:0] rem
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);                                     // R6
  AST_DONE_CLOSES_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (!acq_gate && $past(acq_gate)));                  // R6
  AST_BAD_SIZE_NO_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_framed && !run_st && start_evt && !len_good) |=> !acq_gate); // R8
  AST_RETRIG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_framed && run_st && start_evt && !last_sample) |=> (acq_gate && run_st)); // R7
  AST_CONT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_framed |=> (acq_gate == $past(trig_level)));               // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    run_st |-> (32'(rem) < 32'(MAX_LEN)));                           // R8
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_framed |=> (!run_st && !frame_done));                      // R10
endmodule

bind acq_gate_ctrl acq_gate_chk #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_framed (mode_framed),
  .acq_gate    (acq_gate),
  .frame_done  (frame_done),
  .trig_level  (trig_level),
  .start_evt   (start_evt),
  .len_good    (len_good),
  .run_st      (run_st),
  .last_sample (last_sample),
  .rem         (rem)
);

// File: tb/tb_acq_gate_ctrl.sv
`timescale 1ns/1ps
module tb_acq_gate_ctrl;
  localparam int LW = 25;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_framed = 1'b1;
  logic          trig_src_ext = 1'b0;
  logic          sw_trig = 1'b0;
  logic          ext_trig = 1'b0;
  logic [LW-1:0] frame_len = LW'(8);
  logic          sample_valid = 1'b0;
  logic          acq_gate, frame_done, size_err;

  int checks = 0;
  int fails  = 0;
  int exp_q[$];
  int gated_cnt = 0;

  always #2.5 clk = ~clk;

  acq_gate_ctrl dut (
    .clk(clk), .rst_n(rst_n), .mode_framed(mode_framed),
    .trig_src_ext(trig_src_ext), .sw_trig(sw_trig), .ext_trig(ext_trig),
    .frame_len(frame_len), .sample_valid(sample_valid),
    .acq_gate(acq_gate), .frame_done(frame_done), .size_err(size_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  // Monitor: counts valid samples taken while the gate is open and compares
  // the total against the expected frame length when the done pulse appears.
  initial begin
    forever begin
      @(negedge clk);
      if (frame_done) begin
        if (exp_q.size() == 0) chk("R6 unexpected frame_done", 1, 0);
        else chk("R5 gated samples per frame", gated_cnt, exp_q.pop_front());
        gated_cnt = 0;
      end else if (!acq_gate || !mode_framed) begin
        gated_cnt = 0;
      end
      if (acq_gate && sample_valid && mode_framed) gated_cnt++;
    end
  end

  // Driver: software-triggered framed acquisition.
  task automatic do_frame(input int n, input int stride, input int retrig_at,
                          input int chg_at, input int chg_len);
    bit got = 0;
    frame_len = LW'(n);
    sample_valid = 1'b0;
    tick(2);
    exp_q.push_back(n);
    sw_trig = 1'b1;
    tick(1);
    chk("R5 gate opens after start", int'(acq_gate), 1);
    sw_trig = 1'b0;
    for (int i = 0; i < n * stride + 20; i++) begin
      sample_valid = ((i % stride) == 0);
      if (i == retrig_at)     sw_trig = 1'b1;
      if (i == retrig_at + 1) sw_trig = 1'b0;
      if (i == chg_at)        frame_len = LW'(chg_len);
      tick(1);
      if (frame_done) begin
        chk("R6 gate low with done", int'(acq_gate), 0);
        got = 1;
        break;
      end
    end
    chk("R6 done seen", int'(got), 1);
    sample_valid = 1'b0;
    sw_trig = 1'b0;
    tick(1);
    chk("R6 done lasts one cycle", int'(frame_done), 0);
    tick(3);
    chk("R7 no restart after frame", int'(acq_gate), 0);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit seen;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk("R1 gate after reset", int'(acq_gate), 0);
    chk("R1 done after reset", int'(frame_done), 0);
    chk("R1 size_err after reset", int'(size_err), 0);

    do_frame(8, 1, -10, -10, 0);            // R5 shortest frame
    do_frame(16, 2, -10, -10, 0);           // R5 sparse valid
    do_frame(16, 1, 3, -10, 0);             // R7 retrigger mid-frame
    do_frame(8, 1, -10, 2, 24);             // R9 length change mid-frame
    do_frame(24, 3, -10, -10, 0);           // R9 next frame uses new length

    // R8 legality
    frame_len = LW'(12); tick(1);
    chk("R8 size_err len=12", int'(size_err), 1);
    sw_trig = 1'b1; tick(1); sw_trig = 1'b0; tick(3);
    chk("R8 illegal length keeps gate low", int'(acq_gate), 0);
    frame_len = LW'(0); tick(1);
    chk("R8 size_err len=0", int'(size_err), 1);
    frame_len = LW'((1 << 24) + 8); tick(1);
    chk("R8 size_err len above max", int'(size_err), 1);
    frame_len = LW'(1 << 24); tick(1);
    chk("R8 size_err len=max", int'(size_err), 0);
    frame_len = LW'(8); tick(1);
    chk("R8 size_err len=8", int'(size_err), 0);

    // R2/R3 external source
    trig_src_ext = 1'b1; tick(4);
    sw_trig = 1'b1; tick(4);
    chk("R2 sw_trig ignored under external source", int'(acq_gate), 0);
    sw_trig = 1'b0; tick(2);
    exp_q.push_back(8);
    ext_trig = 1'b1;
    tick(1); chk("R3 gate low after 1 edge", int'(acq_gate), 0);
    tick(1); chk("R3 gate low after 2 edges", int'(acq_gate), 0);
    tick(1); chk("R3 gate high after 3 edges", int'(acq_gate), 1);
    sample_valid = 1'b1;
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      tick(1);
      if (frame_done) begin seen = 1; break; end
    end
    chk("R3 external frame completes", int'(seen), 1);
    sample_valid = 1'b0;
    ext_trig = 1'b0; tick(4);
    trig_src_ext = 1'b0;
    ext_trig = 1'b1; tick(5);
    chk("R2 ext_trig ignored under software source", int'(acq_gate), 0);
    ext_trig = 1'b0; tick(3);

    // R4 continuous mode
    mode_framed = 1'b0; tick(2);
    sw_trig = 1'b1; tick(1);
    chk("R4 gate follows level high", int'(acq_gate), 1);
    tick(4);
    chk("R4 gate stays high with level", int'(acq_gate), 1);
    sw_trig = 1'b0; tick(1);
    chk("R4 gate follows level low", int'(acq_gate), 0);

    // R10 abort on mode change
    mode_framed = 1'b1; frame_len = LW'(64); tick(2);
    sw_trig = 1'b1; sample_valid = 1'b1; tick(1);
    sw_trig = 1'b0; tick(5);
    chk("R10 frame open before abort", int'(acq_gate), 1);
    mode_framed = 1'b0;
    seen = 0;
    tick(1);
    chk("R10 gate low after abort", int'(acq_gate), 0);
    for (int i = 0; i < 80; i++) begin
      tick(1);
      if (frame_done) seen = 1;
    end
    mode_framed = 1'b1; tick(3);
    chk("R10 no done after abort", int'(seen), 0);
    chk("R10 no resume after abort", int'(acq_gate), 0);
    sample_valid = 1'b0;
    tick(3);
    chk("R6 every expected frame completed", exp_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule